// File: doc/BRIEF.md
# Ethernet Flow-Control Frame Generator

This block builds complete 64-byte MAC control frames that ask a link partner to stop or resume sending. When a request is accepted it produces either a classic pause frame, which carries one timer for the whole link, or a per-priority frame, which carries eight per-queue timers and a vector that says which of them apply. Each request chooses between the XOFF form (pause) and the XON form (resume). The frame is sent one byte per cycle on a valid/ready stream that has start and end markers. It covers the bytes from the destination address to the end of the frame check sequence.

Frame contents come from configuration inputs: the local source address, the pause quanta, the selected queue number and a mask of priorities to resume. These inputs are sampled once, in the cycle the request is taken. The block is meant to sit in front of a MAC transmit arbiter. That arbiter adds the preamble and the inter-frame gap.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, out_valid, out_sop and out_eop are low and req_ready is high.
- R2: A request is taken only on a cycle where req_valid and req_ready are both high. The first frame byte appears with out_sop high in the next cycle. req_ready stays low until the last byte has been transferred, and requests made during that time produce no frame.
- R3: Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are cfg_src_addr with bits [47:40] sent first. Bytes 12-13 are 88 08. Bytes 14-15 are 00 01 for a classic frame and 01 01 for a per-priority frame.
- R4: In a classic frame, bytes 16-17 carry cfg_quanta with the high byte first for XOFF, or 00 00 for XON. Bytes 18-59 are zero.
- R5: In a per-priority frame, byte 16 is 00. Byte 17 is the enable vector: for XOFF, bit n is set only when n equals cfg_qnum; for XON, it equals cfg_prio_mask.
- R6: In a per-priority frame, timer n sits at bytes 18+2n (high) and 19+2n (low). For XOFF, timer cfg_qnum holds cfg_quanta and every other timer is zero. For XON, all timers are zero. Bytes 34-59 are zero.
- R7: Bytes 60-63 are the CRC-32 of bytes 0-59, sent low byte first. The CRC uses the reflected polynomial 0xEDB88320 with an initial value of all ones, and the result is complemented.
- R8: While out_valid is high and out_ready is low, out_data, out_sop and out_eop hold their values into the next cycle.
- R9: Each frame is exactly 64 transferred bytes. out_eop is high only on byte 63. out_valid stays high until that byte is taken and drops in the cycle after.
- R10: Changes to the configuration and request-type inputs after acceptance do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame request |
| req_ready | output | 1 | High when idle; a request is taken when both are high |
| req_pfc | input | 1 | 1 = per-priority frame, 0 = classic pause frame |
| req_xon | input | 1 | 1 = XON (resume), 0 = XOFF (pause) |
| cfg_src_addr | input | 48 | Source MAC address |
| cfg_quanta | input | 16 | Pause time in quanta |
| cfg_qnum | input | 3 | Queue whose timer is loaded in a per-priority XOFF |
| cfg_prio_mask | input | NUM_PRIO | Priorities resumed by a per-priority XON |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | BYTE_W | Frame byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |

## Verification
The hardest case to reach is backpressure that lands while the frame check sequence bytes go out, together with changes to the live configuration inputs during a frame. If the CRC register advanced on a stalled cycle, or read the live inputs, the last four bytes would be corrupted. To reach this case, the stimulus holds out_ready low for four of every five cycles across whole frames, so every byte, CRC bytes included, sits stalled for several cycles. In one frame, req_valid stays high with a different frame type and different configuration values for the whole frame. Every frame is then compared byte by byte with an expected image that the bench computes on its own.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
package pfg_pkg;
   localparam int PRIO_N     = 8;
   localparam int QSEL_W     = $clog2(PRIO_N);
   localparam int FRAME_LEN  = 64;
   localparam int BODY_LEN   = 60;
   localparam int IDX_W      = $clog2(FRAME_LEN);
   localparam int TMR_FIRST  = 18;
   localparam int TMR_LAST   = TMR_FIRST + 2 * PRIO_N - 1;

   localparam logic [47:0] CTRL_DST_ADDR = 48'h0180C2000001;
   localparam logic [15:0] CTRL_ETYPE    = 16'h8808;
   localparam logic [31:0] CRC_POLY_REF  = 32'hEDB88320;

   typedef struct packed {
      logic              pfc;
      logic              xon;
      logic [47:0]       src;
      logic [15:0]       quanta;
      logic [QSEL_W-1:0] qnum;
      logic [PRIO_N-1:0] mask;
   } pfg_cfg_t;

   function automatic logic [31:0] crc_step(logic [31:0] c_in, logic [7:0] d);
      logic [31:0] c;
      c = c_in ^ {24'h0, d};
      for (int b = 0; b < 8; b++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY_REF) : (c >> 1);
      end
      return c;
   endfunction
endpackage

// File: rtl/pfg_crc32.sv
`timescale 1ns/1ps
module pfg_crc32 (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        en,
   input  logic [7:0]  data,
   output logic [31:0] crc
);
   import pfg_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         crc <= '1;
      end else if (en) begin
         crc <= crc_step(crc, data);
      end
   end
endmodule

// File: rtl/pfg_field_mux.sv
`timescale 1ns/1ps
module pfg_field_mux
   import pfg_pkg::*;
(
   input  pfg_cfg_t         cfg,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       byte_o
);
   logic [15:0]       timer_w [PRIO_N];
   logic [PRIO_N-1:0] en_vec;
   logic [IDX_W-1:0]  toff;
   logic [15:0]       tsel;

   generate
      for (genvar n = 0; n < PRIO_N; n++) begin : g_tmr
         assign timer_w[n] = (!cfg.xon && cfg.qnum == QSEL_W'(n)) ? cfg.quanta : 16'h0000;
         assign en_vec[n]  = cfg.xon ? cfg.mask[n] : (cfg.qnum == QSEL_W'(n));
      end
   endgenerate

   assign toff = idx - IDX_W'(TMR_FIRST);
   assign tsel = timer_w[toff[QSEL_W:1]];

   always_comb begin
      byte_o = 8'h00;
      if (idx < IDX_W'(6)) begin
         byte_o = 8'(CTRL_DST_ADDR >> (8 * (5 - int'(idx))));
      end else if (idx < IDX_W'(12)) begin
         byte_o = 8'(cfg.src >> (8 * (11 - int'(idx))));
      end else if (idx == IDX_W'(12)) begin
         byte_o = CTRL_ETYPE[15:8];
      end else if (idx == IDX_W'(13)) begin
         byte_o = CTRL_ETYPE[7:0];
      end else if (idx == IDX_W'(14)) begin
         byte_o = cfg.pfc ? 8'h01 : 8'h00;
      end else if (idx == IDX_W'(15)) begin
         byte_o = 8'h01;
      end else if (idx == IDX_W'(16)) begin
         byte_o = (cfg.pfc || cfg.xon) ? 8'h00 : cfg.quanta[15:8];
      end else if (idx == IDX_W'(17)) begin
         if (cfg.pfc)       byte_o = 8'(en_vec);
         else if (!cfg.xon) byte_o = cfg.quanta[7:0];
      end else if (cfg.pfc && idx <= IDX_W'(TMR_LAST)) begin
         byte_o = idx[0] ? tsel[7:0] : tsel[15:8];
      end
   end
endmodule

// File: rtl/pause_frame_gen.sv
`timescale 1ns/1ps
module pause_frame_gen
   import pfg_pkg::*;
#(
   parameter int NUM_PRIO = 8,
   parameter int BYTE_W   = 8
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_pfc,
   input  logic                        req_xon,
   input  logic [47:0]                 cfg_src_addr,
   input  logic [15:0]                 cfg_quanta,
   input  logic [$clog2(NUM_PRIO)-1:0] cfg_qnum,
   input  logic [NUM_PRIO-1:0]         cfg_prio_mask,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [BYTE_W-1:0]           out_data,
   output logic                        out_sop,
   output logic                        out_eop
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] FCS_IDX  = IDX_W'(BODY_LEN);

   generate
      if (NUM_PRIO != PRIO_N) begin : g_bad_prio
         $error("pause_frame_gen: NUM_PRIO must be 8");
      end
      if (BYTE_W != 8) begin : g_bad_width
         $error("pause_frame_gen: BYTE_W must be 8");
      end
   endgenerate

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   pfg_cfg_t         cfg_q;
   logic             accept, xfer;
   logic [7:0]       body_byte, fcs_byte;
   logic [31:0]      crc_q, fcs;

   assign accept = req_valid && !busy_q;
   assign xfer   = busy_q && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         cfg_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         cfg_q  <= '{pfc: req_pfc, xon: req_xon, src: cfg_src_addr,
                     quanta: cfg_quanta, qnum: cfg_qnum, mask: cfg_prio_mask};
      end else if (xfer) begin
         if (idx_q == LAST_IDX) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   pfg_field_mux u_mux (
      .cfg    (cfg_q),
      .idx    (idx_q),
      .byte_o (body_byte)
   );

   pfg_crc32 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .en    (xfer && idx_q < FCS_IDX),
      .data  (body_byte),
      .crc   (crc_q)
   );

   assign fcs      = ~crc_q;
   assign fcs_byte = 8'(fcs >> {idx_q[1:0], 3'b000});

   assign req_ready = !busy_q;
   assign out_valid = busy_q;
   assign out_data  = (idx_q >= FCS_IDX) ? fcs_byte : body_byte;
   assign out_sop   = busy_q && idx_q == '0;
   assign out_eop   = busy_q && idx_q == LAST_IDX;

   // R8
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

   // R9
   idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_eop |=> !out_valid);

   // R9
   no_early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !(out_ready && out_eop) |=> out_valid);

   // R2
   start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> out_valid && out_sop && !req_ready);

   // R9
   marker_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_sop && out_eop));
endmodule

// File: tb/pause_frame_gen_tb_top.sv
`timescale 1ns/1ps
module pause_frame_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_pfc = 1'b0;
   logic        req_xon = 1'b0;
   logic [47:0] cfg_src_addr = '0;
   logic [15:0] cfg_quanta = '0;
   logic [2:0]  cfg_qnum = '0;
   logic [7:0]  cfg_prio_mask = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic        out_sop;
   logic        out_eop;

   int tests_run = 0;
   int tests_failed = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pause_frame_gen dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_pfc(req_pfc), .req_xon(req_xon), .cfg_src_addr(cfg_src_addr),
      .cfg_quanta(cfg_quanta), .cfg_qnum(cfg_qnum), .cfg_prio_mask(cfg_prio_mask),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests_run++;
      if (!ok) begin
         tests_failed++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(logic [31:0] c, logic [7:0] d);
      logic [31:0] r = c ^ {24'h0, d};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   function automatic string region(input int i, input bit pfc);
      if (i < 16)  return "R3";
      if (i >= 60) return "R7";
      if (!pfc)    return "R4";
      if (i < 18)  return "R5";
      return "R6";
   endfunction

   function automatic bit ready_for(input int mode, input int cyc);
      if (mode == 1) return (cyc % 2) == 1;
      if (mode == 2) return (cyc % 5) == 4;
      return 1'b1;
   endfunction

   task automatic run_frame(input bit pfc, input bit xon, input logic [47:0] sa,
                            input logic [15:0] q, input logic [2:0] qn, input logic [7:0] mask,
                            input int mode, input bit disturb, input string name);
      logic [7:0]  e [64];
      logic [7:0]  got [64];
      bit          sopv [64];
      bit          eopv [64];
      logic [31:0] c;
      int          cnt = 0;
      int          cyc = 0;
      int          stall_bad = 0;
      bit          prev_stall = 1'b0;
      logic [7:0]  prev_data = '0;
      bit          r;
      string       tg;

      for (int i = 0; i < 64; i++) e[i] = 8'h00;
      e[0] = 8'h01; e[1] = 8'h80; e[2] = 8'hC2; e[3] = 8'h00; e[4] = 8'h00; e[5] = 8'h01;
      for (int i = 0; i < 6; i++) e[6+i] = sa[47-8*i -: 8];
      e[12] = 8'h88; e[13] = 8'h08;
      e[14] = pfc ? 8'h01 : 8'h00; e[15] = 8'h01;
      if (!pfc) begin
         if (!xon) begin e[16] = q[15:8]; e[17] = q[7:0]; end
      end else begin
         e[17] = xon ? mask : (8'h01 << qn);
         if (!xon) begin e[18+2*qn] = q[15:8]; e[19+2*qn] = q[7:0]; end
      end
      c = 32'hFFFFFFFF;
      for (int i = 0; i < 60; i++) c = ref_crc(c, e[i]);
      c = ~c;
      for (int k = 0; k < 4; k++) e[60+k] = c[8*k +: 8];

      @(negedge clk);
      check(req_ready == 1'b1, "R2", {name, " idle before request"}, 32'(req_ready), 1);
      req_pfc = pfc; req_xon = xon; cfg_src_addr = sa; cfg_quanta = q;
      cfg_qnum = qn; cfg_prio_mask = mask; req_valid = 1'b1;
      @(negedge clk);
      check(out_valid && out_sop, "R2", {name, " first byte after accept"},
            32'({out_valid, out_sop}), 32'h3);
      if (disturb) begin
         // R10: live inputs change and request stays high during the frame
         req_pfc = ~pfc; req_xon = ~xon; cfg_src_addr = ~sa; cfg_quanta = ~q;
         cfg_qnum = ~qn; cfg_prio_mask = ~mask;
      end else begin
         req_valid = 1'b0;
      end
      while (cnt < 64 && cyc < 2000) begin
         r = ready_for(mode, cyc);
         out_ready = r;
         if (prev_stall && out_data !== prev_data) stall_bad++;
         prev_stall = out_valid && !r;
         prev_data = out_data;
         if (out_valid && r) begin
            got[cnt] = out_data; sopv[cnt] = out_sop; eopv[cnt] = out_eop;
            if (out_eop) req_valid = 1'b0;
            cnt++;
         end
         cyc++;
         @(negedge clk);
      end
      out_ready = 1'b0;
      check(cnt == 64, "R9", {name, " byte count"}, 32'(cnt), 64);
      for (int i = 0; i < cnt; i++) begin
         tg = region(i, pfc);
         check(got[i] === e[i], disturb ? {tg, "/R10"} : tg,
               $sformatf("%s byte %0d", name, i), 32'(got[i]), 32'(e[i]));
         check(sopv[i] == (i == 0) && eopv[i] == (i == 63), "R9",
               $sformatf("%s markers byte %0d", name, i),
               32'({sopv[i], eopv[i]}), 32'({i == 0, i == 63}));
      end
      check(stall_bad == 0, "R8", {name, " data held while stalled"}, 32'(stall_bad), 0);
      check(out_valid == 1'b0, disturb ? "R2" : "R9", {name, " idle after last byte"},
            32'(out_valid), 0);
      @(negedge clk);
      check(out_valid == 1'b0 && req_ready == 1'b1, "R2", {name, " no extra frame"},
            32'({out_valid, req_ready}), 32'h1);
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      check(out_valid == 1'b0 && out_sop == 1'b0 && out_eop == 1'b0, "R1", "outputs in reset",
            32'({out_valid, out_sop, out_eop}), 0);
      check(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && req_ready == 1'b1, "R1", "idle after reset",
            32'({out_valid, req_ready}), 32'h1);
   endtask

   initial begin
      test_reset();
      run_frame(1'b0, 1'b0, 48'h0A1B2C3D4E5F, 16'hBEEF, 3'd0, 8'h00, 0, 1'b0, "std_xoff");
      run_frame(1'b0, 1'b1, 48'h665544332211, 16'h1234, 3'd5, 8'hFF, 1, 1'b0, "std_xon");
      run_frame(1'b1, 1'b0, 48'h00E0FEED0001, 16'hFFFF, 3'd0, 8'h3C, 0, 1'b0, "pfc_xoff_q0");
      run_frame(1'b1, 1'b0, 48'h123456789ABC, 16'h00A7, 3'd7, 8'h00, 2, 1'b0, "pfc_xoff_q7");
      run_frame(1'b1, 1'b1, 48'hCAFEF00D0042, 16'h7777, 3'd3, 8'hA5, 1, 1'b0, "pfc_xon");
      run_frame(1'b0, 1'b0, 48'h010203040506, 16'h0101, 3'd2, 8'h0F, 2, 1'b1, "std_xoff_disturb");
      run_frame(1'b1, 1'b0, 48'hFFFFFFFFFFFF, 16'h8001, 3'd4, 8'h00, 2, 1'b1, "pfc_xoff_disturb");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end
endmodule